// File: doc/BRIEF.md
# Eight-Channel Descriptor-Chained DMA Engine

This block moves data between two address regions on behalf of up to eight independent channels. Each channel copies a run of elements one way, from a source area to a destination area, and either area may be ordinary memory or a single peripheral data register. A channel is set up through a small write-only configuration port. Software gives it a source address, a destination address, a control word and an optional pointer to a further descriptor, and then starts it. All channels share one generic 32-bit memory port that carries single-word read and write requests with byte enables and a grant handshake.

When more than one channel is ready, the lowest-numbered one is served first. It keeps the port for one burst of elements and then gives up the port for a new arbitration round. Every element is first read into a one-word holding register. Bytes are taken from the lanes the source address selects and may be reordered for big-endian handling. The element is then written to the lanes the destination address selects. When a descriptor runs out, the channel either fetches the next four-word descriptor from memory and carries on, or ends the chain, raises its done flag and drops its active bit.

Top module: `dma_ll_ctrl`

## Requirements
- R1: After a synchronous reset, `mem_req`, every `ch_active` bit and every `ch_done` bit are 0.
- R2: Configuration writes select the channel with `cfg_addr[5:3]` and the register with `cfg_addr[2:0]`: 0 source address, 1 destination address, 2 next-descriptor pointer, 3 control word, 4 start. Writing 1 to bit 0 of start sets the active bit and clears the done flag. Writing 0 clears the active bit.
- R3: Control word fields: bits 15:0 element count, 17:16 width code (0 = 8-bit, 1 = 16-bit, 2 = 32-bit), 18 source increment, 19 destination increment, 23:20 burst length minus one, 24 big-endian, 25 wait for the peripheral request line.
- R4: An element is read from the byte lanes starting at lane `addr[1:0]` of the aligned source word. It is written to the lanes starting at `dst[1:0]`, and `mem_be` marks exactly those 1, 2 or 4 lanes.
- R5: With the big-endian bit set, the bytes of each element are written in reverse order. For 8-bit elements this changes nothing.
- R6: The source and destination addresses advance by the element size after each element when their increment bit is set. Otherwise they stay fixed.
- R7: At each arbitration the ready channel with the lowest index wins.
- R8: A winning channel moves up to burst-length elements without interruption, and arbitration happens again only afterwards.
- R9: A channel with the request-wait bit set issues no memory access while its `dreq` line is low.
- R10: When the count reaches zero and the next pointer is nonzero, the channel reads four words at pointer offsets 0, 4, 8 and 12 as source, destination, next pointer and control word, and continues with them.
- R11: When the count reaches zero and the next pointer is zero, the channel sets its `ch_done` bit and clears its `ch_active` bit.
- R12: Each accepted read of an element is followed by the write of that element, and a request not yet granted holds its address, direction and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Channel (5:3) and register (2:0) select |
| cfg_wdata | input | 32 | Configuration write data |
| dreq | input | 8 | Per-channel peripheral request lines |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_gnt | input | 1 | Access accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with the grant |
| ch_active | output | 8 | Per-channel active bits |
| ch_done | output | 8 | Per-channel sticky done flags |

## Verification
The case of interest is a higher-priority request that arrives while a lower-priority channel is partway through a burst. The bench starts channel 6 on a long transfer. Right after its first write is accepted, the bench raises the request of channel 1. It then reads the logged order of write addresses: all four writes of channel 6's burst must come first, then both writes of channel 1, then the rest of channel 6. A second case raises two requests in the same cycle and expects the lower index to write first.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int DW = 32;
    localparam int NB = DW / 8;
    localparam int LW = $clog2(NB);

    typedef enum logic [1:0] {
        WID_8  = 2'd0,
        WID_16 = 2'd1,
        WID_32 = 2'd2
    } wid_e;

    typedef struct packed {
        logic [5:0]  rsv;
        logic        use_req;
        logic        big_end;
        logic [3:0]  burst_m1;
        logic        dst_inc;
        logic        src_inc;
        logic [1:0]  width;
        logic [15:0] count;
    } ctrl_t;

    typedef enum logic [1:0] {
        S_ARB   = 2'd0,
        S_RD    = 2'd1,
        S_WR    = 2'd2,
        S_FETCH = 2'd3
    } eng_st_e;

    localparam logic [2:0] REG_SRC   = 3'd0;
    localparam logic [2:0] REG_DST   = 3'd1;
    localparam logic [2:0] REG_NEXT  = 3'd2;
    localparam logic [2:0] REG_CTRL  = 3'd3;
    localparam logic [2:0] REG_START = 3'd4;

    function automatic logic [2:0] elem_bytes(input logic [1:0] w);
        case (w)
            WID_8:   elem_bytes = 3'd1;
            WID_16:  elem_bytes = 3'd2;
            default: elem_bytes = 3'd4;
        endcase
    endfunction

    function automatic logic [DW-1:0] swap_elem(input logic [DW-1:0] v, input logic [1:0] w);
        case (w)
            WID_8:   swap_elem = v;
            WID_16:  swap_elem = {16'd0, v[7:0], v[15:8]};
            default: swap_elem = {v[7:0], v[15:8], v[23:16], v[31:24]};
        endcase
    endfunction

endpackage

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_mask
            if (gi == 0) begin : g_first
                assign gnt[gi] = req[gi];
            end else begin : g_rest
                assign gnt[gi] = req[gi] & ~(|req[gi-1:0]);
            end
        end
    endgenerate

    assign any = |req;

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) idx = idx | IW'(i);
        end
    end

    always_comb begin
        // R7
        onehot_grant_chk: assert ($onehot0(gnt));
        // R7
        lowest_wins_chk: assert (((gnt - N'(1)) & req) == '0 || gnt == '0);
        // R7
        grant_when_req_chk: assert ((|gnt) == any);
    end

endmodule

// File: rtl/dma_lane_pack.sv
module dma_lane_pack
    import dma_pkg::*;
(
    input  logic [DW-1:0] rd_word,
    input  logic [LW-1:0] rd_lane,
    input  logic [LW-1:0] wr_lane,
    input  logic [1:0]    width,
    input  logic          big_end,
    input  logic [DW-1:0] hold,
    output logic [DW-1:0] elem,
    output logic [DW-1:0] wdata,
    output logic [NB-1:0] be
);

    logic [DW-1:0] shifted;
    logic [DW-1:0] raw;

    always_comb begin
        shifted = rd_word >> {rd_lane, 3'b000};
        case (width)
            WID_8:   raw = {24'd0, shifted[7:0]};
            WID_16:  raw = {16'd0, shifted[15:0]};
            default: raw = shifted;
        endcase
        elem = big_end ? swap_elem(raw, width) : raw;
    end

    always_comb begin
        case (width)
            WID_8: begin
                wdata = {NB{hold[7:0]}};
                be    = NB'(1) << wr_lane;
            end
            WID_16: begin
                wdata = {(NB/2){hold[15:0]}};
                be    = wr_lane[1] ? 4'b1100 : 4'b0011;
            end
            default: begin
                wdata = hold;
                be    = '1;
            end
        endcase
    end

    always_comb begin
        // R4
        be_width_chk: assert (width == 2'd3 || $countones(be) == int'(elem_bytes(width)));
    end

endmodule

// File: rtl/dma_ll_ctrl.sv
module dma_ll_ctrl
    import dma_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 32,
    localparam int CIW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CIW+2:0]   cfg_addr,
    input  logic [DW-1:0]    cfg_wdata,
    input  logic [NCH-1:0]   dreq,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic [NB-1:0]    mem_be,
    input  logic             mem_gnt,
    input  logic [DW-1:0]    mem_rdata,
    output logic [NCH-1:0]   ch_active,
    output logic [NCH-1:0]   ch_done
);

    logic [AW-1:0]  src_q [NCH];
    logic [AW-1:0]  dst_q [NCH];
    logic [AW-1:0]  nxt_q [NCH];
    ctrl_t          ctl_q [NCH];
    logic [NCH-1:0] en_q;
    logic [NCH-1:0] done_q;

    eng_st_e        st;
    logic [CIW-1:0] cur;
    logic [3:0]     beats;
    logic [1:0]     fidx;
    logic [AW-1:0]  fptr;
    logic [DW-1:0]  hold;

    logic [NCH-1:0] pend;
    logic [NCH-1:0] a_gnt;
    logic [CIW-1:0] a_idx;
    logic           a_any;
    logic [CIW-1:0] cfg_ch;
    logic [DW-1:0]  pk_elem;
    logic [DW-1:0]  pk_wdata;
    logic [NB-1:0]  pk_be;
    ctrl_t          cur_ctl;

    assign cfg_ch  = cfg_addr[CIW+2:3];
    assign cur_ctl = ctl_q[cur];

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_pend
            assign pend[gi] = en_q[gi] &
                ((ctl_q[gi].count == 16'd0) | ~ctl_q[gi].use_req | dreq[gi]);
        end
    endgenerate

    dma_prio_arb #(.N(NCH)) arb_i (
        .req (pend),
        .gnt (a_gnt),
        .idx (a_idx),
        .any (a_any)
    );

    dma_lane_pack pack_i (
        .rd_word (mem_rdata),
        .rd_lane (src_q[cur][LW-1:0]),
        .wr_lane (dst_q[cur][LW-1:0]),
        .width   (cur_ctl.width),
        .big_end (cur_ctl.big_end),
        .hold    (hold),
        .elem    (pk_elem),
        .wdata   (pk_wdata),
        .be      (pk_be)
    );

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_be    = '0;
        case (st)
            S_RD: begin
                mem_req  = 1'b1;
                mem_addr = {src_q[cur][AW-1:LW], {LW{1'b0}}};
            end
            S_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {dst_q[cur][AW-1:LW], {LW{1'b0}}};
                mem_wdata = pk_wdata;
                mem_be    = pk_be;
            end
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = fptr + AW'({fidx, 2'b00});
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) begin
                src_q[i] <= '0;
                dst_q[i] <= '0;
                nxt_q[i] <= '0;
                ctl_q[i] <= '0;
            end
            en_q   <= '0;
            done_q <= '0;
            st     <= S_ARB;
            cur    <= '0;
            beats  <= '0;
            fidx   <= '0;
            fptr   <= '0;
            hold   <= '0;
        end else begin
            if (cfg_we) begin
                case (cfg_addr[2:0])
                    REG_SRC:   src_q[cfg_ch] <= AW'(cfg_wdata);
                    REG_DST:   dst_q[cfg_ch] <= AW'(cfg_wdata);
                    REG_NEXT:  nxt_q[cfg_ch] <= AW'(cfg_wdata);
                    REG_CTRL:  ctl_q[cfg_ch] <= ctrl_t'(cfg_wdata);
                    REG_START: begin
                        en_q[cfg_ch] <= cfg_wdata[0];
                        if (cfg_wdata[0]) done_q[cfg_ch] <= 1'b0;
                    end
                    default: ;
                endcase
            end
            case (st)
                S_ARB: begin
                    if (a_any) begin
                        cur   <= a_idx;
                        beats <= ctl_q[a_idx].burst_m1;
                        if (ctl_q[a_idx].count != 16'd0) begin
                            st <= S_RD;
                        end else if (nxt_q[a_idx] != '0) begin
                            fptr <= nxt_q[a_idx];
                            fidx <= '0;
                            st   <= S_FETCH;
                        end else begin
                            done_q[a_idx] <= 1'b1;
                            en_q[a_idx]   <= 1'b0;
                        end
                    end
                end
                S_RD: begin
                    if (mem_gnt) begin
                        hold <= pk_elem;
                        st   <= S_WR;
                    end
                end
                S_WR: begin
                    if (mem_gnt) begin
                        if (cur_ctl.src_inc)
                            src_q[cur] <= src_q[cur] + AW'(elem_bytes(cur_ctl.width));
                        if (cur_ctl.dst_inc)
                            dst_q[cur] <= dst_q[cur] + AW'(elem_bytes(cur_ctl.width));
                        ctl_q[cur].count <= cur_ctl.count - 16'd1;
                        if (cur_ctl.count == 16'd1) begin
                            if (nxt_q[cur] != '0) begin
                                fptr <= nxt_q[cur];
                                fidx <= '0;
                                st   <= S_FETCH;
                            end else begin
                                done_q[cur] <= 1'b1;
                                en_q[cur]   <= 1'b0;
                                st          <= S_ARB;
                            end
                        end else if (beats == 4'd0) begin
                            st <= S_ARB;
                        end else begin
                            beats <= beats - 4'd1;
                            st    <= S_RD;
                        end
                    end
                end
                S_FETCH: begin
                    if (mem_gnt) begin
                        case (fidx)
                            2'd0:    src_q[cur] <= AW'(mem_rdata);
                            2'd1:    dst_q[cur] <= AW'(mem_rdata);
                            2'd2:    nxt_q[cur] <= AW'(mem_rdata);
                            default: ctl_q[cur] <= ctrl_t'(mem_rdata);
                        endcase
                        if (fidx == 2'd3) st <= S_ARB;
                        else fidx <= fidx + 2'd1;
                    end
                end
                default: st <= S_ARB;
            endcase
        end
    end

    assign ch_active = en_q;
    assign ch_done   = done_q;

    // R8
    burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st != S_ARB) |=> (st == S_ARB || $stable(cur)));

    // R11
    chain_end_chk: assert property (@(posedge clk) disable iff (rst)
        ((ch_done & ~$past(ch_done) & ch_active) == '0));

    // R12
    req_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                    && $stable(mem_wdata)));

    // R12
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_RD && mem_gnt) |=> (mem_req && mem_we));

endmodule

// File: tb/dma_ll_ctrl_tb.sv
module dma_ll_ctrl_tb_top;
    import dma_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [7:0]  dreq = '0;
    logic        mem_req, mem_we, mem_gnt;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;
    logic [7:0]  ch_active, ch_done;

    int checks = 0;
    int fails  = 0;

    logic [31:0] mem  [256];
    logic [31:0] expm [256];
    logic        tb_we = 1'b0;
    logic [7:0]  tb_widx = '0;
    logic [31:0] tb_wdat = '0;
    logic        log_clr = 1'b0;
    logic [31:0] wlog [64];
    int          wn = 0;
    int          req_cnt = 0;
    logic        stall_en = 1'b0;
    logic [7:0]  lf = 8'h5A;

    always #4 clk = ~clk;

    dma_ll_ctrl dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .dreq(dreq), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .ch_active(ch_active),
        .ch_done(ch_done)
    );

    assign mem_rdata = mem[mem_addr[9:2]];

    always @(negedge clk) begin
        lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        mem_gnt <= stall_en ? lf[0] : 1'b1;
    end

    always @(posedge clk) begin
        if (tb_we) mem[tb_widx] <= tb_wdat;
        if (log_clr) begin
            wn <= 0;
            req_cnt <= 0;
        end else begin
            if (mem_req) req_cnt <= req_cnt + 1;
            if (mem_req && mem_we && mem_gnt) begin
                if (wn < 64) wlog[wn] <= mem_addr;
                wn <= wn + 1;
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end
        end
    end

    function automatic logic [31:0] mk_ctl(input int cnt, input int w, input bit si,
                                           input bit di, input int bm1, input bit bend,
                                           input bit ureq);
        mk_ctl = {6'd0, ureq, bend, 4'(bm1), di, si, 2'(w), 16'(cnt)};
    endfunction

    typedef struct packed {
        logic [2:0]  ch;
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] ctl;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 32'h100, 32'h200, mk_ctl(4, 2, 1, 1, 1, 0, 0)},
        '{3'd3, 32'h101, 32'h222, mk_ctl(5, 0, 1, 1, 3, 0, 0)},
        '{3'd5, 32'h110, 32'h242, mk_ctl(3, 1, 1, 1, 0, 1, 0)},
        '{3'd7, 32'h120, 32'h260, mk_ctl(2, 2, 1, 1, 7, 1, 0)},
        '{3'd2, 32'h133, 32'h280, mk_ctl(3, 0, 0, 1, 2, 0, 0)},
        '{3'd1, 32'h140, 32'h2A2, mk_ctl(3, 1, 1, 0, 2, 0, 0)}
    };
    localparam string VTAG [NV] = '{"R4 R6", "R4 R3", "R5 R4", "R5 R8", "R6 src", "R6 dst"};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rdb(input logic [31:0] a);
        rdb = expm[a[9:2]][8*a[1:0] +: 8];
    endfunction

    task automatic wrb(input logic [31:0] a, input logic [7:0] v);
        expm[a[9:2]][8*a[1:0] +: 8] = v;
    endtask

    task automatic model_copy(input logic [31:0] s0, input logic [31:0] d0,
                              input logic [31:0] c);
        int n;
        logic [31:0] s;
        logic [31:0] d;
        logic [7:0] b [4];
        n = 1 << c[17:16];
        s = s0;
        d = d0;
        for (int k = 0; k < int'(c[15:0]); k++) begin
            for (int j = 0; j < n; j++) b[j] = rdb(s + 32'(j));
            for (int j = 0; j < n; j++) wrb(d + 32'(j), c[24] ? b[n-1-j] : b[j]);
            if (c[18]) s = s + 32'(n);
            if (c[19]) d = d + 32'(n);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] v);
        @(negedge clk);
        tb_we = 1'b1;
        tb_widx = a[9:2];
        tb_wdat = v;
        expm[a[9:2]] = v;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic cfg(input int ch, input logic [2:0] r, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = {3'(ch), r};
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d,
                         input logic [31:0] n, input logic [31:0] c);
        cfg(ch, REG_SRC, s);
        cfg(ch, REG_DST, d);
        cfg(ch, REG_NEXT, n);
        cfg(ch, REG_CTRL, c);
    endtask

    task automatic wait_done(input int ch, input string tag);
        int t = 0;
        while (!ch_done[ch] && t < 4000) begin
            @(negedge clk);
            t++;
        end
        check({tag, " done flag"}, 32'(ch_done[ch]), 32'd1);
        check({tag, " active cleared"}, 32'(ch_active[ch]), 32'd0);
    endtask

    task automatic cmp_mem(input string tag);
        int bad = -1;
        for (int i = 0; i < 256; i++)
            if (bad < 0 && mem[i] !== expm[i]) bad = i;
        checks++;
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s: word %0h act=%h exp=%h", tag, bad * 4, mem[bad], expm[bad]);
        end
    endtask

    task automatic clear_log();
        @(negedge clk);
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: act=running exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        for (int i = 0; i < 256; i++) begin
            logic [7:0] x;
            x = 8'(i);
            @(negedge clk);
            tb_we = 1'b1;
            tb_widx = x;
            tb_wdat = {x ^ 8'hA5, x, x + 8'h3C, ~x};
            expm[i] = {x ^ 8'hA5, x, x + 8'h3C, ~x};
        end
        @(negedge clk);
        tb_we = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 mem_req", 32'(mem_req), 32'd0);
        check("R1 ch_active", 32'(ch_active), 32'd0);
        check("R1 ch_done", 32'(ch_done), 32'd0);

        // R2 R3 R4 R5 R6: table of single-descriptor copies
        for (int v = 0; v < NV; v++) begin
            setup(int'(VECS[v].ch), VECS[v].src, VECS[v].dst, 32'd0, VECS[v].ctl);
            model_copy(VECS[v].src, VECS[v].dst, VECS[v].ctl);
            cfg(int'(VECS[v].ch), REG_START, 32'd1);
            check("R2 start sets active", 32'(ch_active[VECS[v].ch] | ch_done[VECS[v].ch]), 32'd1);
            wait_done(int'(VECS[v].ch), {"R11 ", VTAG[v]});
            cmp_mem({"vector ", VTAG[v]});
        end

        // R10 R11: two-element chain through a descriptor at 0x3C0
        poke(32'h3C0, 32'h190);
        poke(32'h3C4, 32'h320);
        poke(32'h3C8, 32'h0);
        poke(32'h3CC, mk_ctl(2, 1, 1, 1, 3, 1, 0));
        setup(4, 32'h180, 32'h300, 32'h3C0, mk_ctl(2, 2, 1, 1, 3, 0, 0));
        model_copy(32'h180, 32'h300, mk_ctl(2, 2, 1, 1, 3, 0, 0));
        model_copy(32'h190, 32'h320, mk_ctl(2, 1, 1, 1, 3, 1, 0));
        cfg(4, REG_START, 32'd1);
        wait_done(4, "R11 chain");
        cmp_mem("R10 chained copy");

        // R9 gating, then R7 simultaneous requests
        setup(6, 32'h1A0, 32'h340, 32'd0, mk_ctl(2, 2, 1, 1, 3, 0, 1));
        setup(1, 32'h1B0, 32'h360, 32'd0, mk_ctl(2, 2, 1, 1, 3, 0, 1));
        cfg(6, REG_START, 32'd1);
        cfg(1, REG_START, 32'd1);
        clear_log();
        repeat (30) @(negedge clk);
        check("R9 no access without dreq", 32'(req_cnt), 32'd0);
        check("R9 still active", 32'(ch_active & 8'h42), 32'h42);
        model_copy(32'h1A0, 32'h340, mk_ctl(2, 2, 1, 1, 3, 0, 1));
        model_copy(32'h1B0, 32'h360, mk_ctl(2, 2, 1, 1, 3, 0, 1));
        dreq = 8'h42;
        wait_done(6, "R11 prio ch6");
        wait_done(1, "R11 prio ch1");
        dreq = 8'h00;
        check("R7 first write ch1", wlog[0], 32'h360);
        check("R7 second write ch1", wlog[1], 32'h364);
        check("R7 third write ch6", wlog[2], 32'h340);
        cmp_mem("R7 image");

        // R8: higher request arrives inside a burst
        setup(6, 32'h1C0, 32'h380, 32'd0, mk_ctl(8, 2, 1, 1, 3, 0, 1));
        setup(1, 32'h1E0, 32'h3A0, 32'd0, mk_ctl(2, 2, 1, 1, 3, 0, 1));
        cfg(6, REG_START, 32'd1);
        cfg(1, REG_START, 32'd1);
        clear_log();
        model_copy(32'h1C0, 32'h380, mk_ctl(8, 2, 1, 1, 3, 0, 1));
        model_copy(32'h1E0, 32'h3A0, mk_ctl(2, 2, 1, 1, 3, 0, 1));
        dreq = 8'h40;
        begin
            int t = 0;
            while (wn < 1 && t < 1000) begin
                @(negedge clk);
                t++;
            end
        end
        dreq = 8'h42;
        wait_done(6, "R11 burst ch6");
        wait_done(1, "R11 burst ch1");
        dreq = 8'h00;
        begin
            logic [31:0] ord [10];
            ord = '{32'h380, 32'h384, 32'h388, 32'h38C, 32'h3A0, 32'h3A4,
                    32'h390, 32'h394, 32'h398, 32'h39C};
            for (int k = 0; k < 10; k++) check($sformatf("R8 write order %0d", k), wlog[k], ord[k]);
        end
        cmp_mem("R8 image");

        // R12: random grant stalls during a 16-bit copy
        stall_en = 1'b1;
        setup(0, 32'h104, 32'h3E0, 32'd0, mk_ctl(6, 1, 1, 1, 2, 0, 0));
        model_copy(32'h104, 32'h3E0, mk_ctl(6, 1, 1, 1, 2, 0, 0));
        cfg(0, REG_START, 32'd1);
        wait_done(0, "R12 stalled");
        stall_en = 1'b0;
        cmp_mem("R12 stalled image");

        // R2: start written with 0 leaves channel idle
        setup(3, 32'h100, 32'h2F0, 32'd0, mk_ctl(1, 2, 1, 1, 0, 0, 0));
        cfg(3, REG_START, 32'd0);
        clear_log();
        repeat (20) @(negedge clk);
        check("R2 stop keeps idle", 32'(req_cnt), 32'd0);
        cmp_mem("R2 idle image");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule